// File: doc/BRIEF.md
# Memory Operation Queue with Result-Bus Snooping

This block holds descriptors of memory operations that have already been issued and are waiting for the memory port. Each descriptor records whether it is a load or a store and the effective address, which is computed before the operation is handed to the queue. A store also carries its write data. That data is either a value supplied at allocation or, when the producing instruction is still executing, the producer's tag together with a flag marking the data as missing.

While a store waits, its slot watches the shared result bus. When the bus carries a matching tag, the slot copies the broadcast value and becomes complete. Only the oldest entry can be offered to the single memory port. A load is offered as soon as it is oldest. A store is offered only once its data is present. An offer is taken on a cycle in which the memory side signals ready.

The queue gives every new entry an identifier, which is the slot it occupies. That identifier travels with the operation to memory, so the memory side can tag a load's result with it when returning the result to the bus.

Top module: `memop_queue`

## Requirements
- R1: After reset the queue is empty: `full` is 0, `mem_valid` is 0 and the next identifier `alloc_id` is 0.
- R2: Entries leave through the memory port in exactly the order in which they were accepted.
- R3: When `DEPTH` entries are held, `full` is 1 and an allocation request is ignored: no entry is added, and the refused operation never appears at the memory port.
- R4: A load at the head is offered (`mem_valid`=1, `mem_is_store`=0) with its address, whether or not older or younger stores are waiting.
- R5: A store allocated with `alloc_data_ok`=1 is offered with `mem_is_store`=1 and the value given on `alloc_data`.
- R6: A store at the head whose data is missing keeps `mem_valid` at 0. The entries behind it are not bypassed.
- R7: A waiting store whose tag equals `bus_tag` while `bus_valid`=1 takes `bus_data` as its data and is offered from the next cycle. A broadcast with a different tag leaves it waiting.
- R8: When a waiting store is allocated in the same cycle as a broadcast of its own tag, the broadcast value is captured at allocation.
- R9: While `mem_valid`=1 and `mem_ready`=0, the head is held: `mem_valid`, `mem_addr`, `mem_wdata`, `mem_is_store` and `mem_id` do not change.
- R10: The identifier of an accepted entry is the value on `alloc_id` in its allocation cycle. Identifiers count up from 0 and wrap after `DEPTH`-1. The same identifier appears on `mem_id` when the entry is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Request to add an entry |
| alloc_is_store | input | 1 | 1 = store, 0 = load |
| alloc_addr | input | ADDR_W | Effective address |
| alloc_data_ok | input | 1 | Store data present on alloc_data |
| alloc_data | input | DATA_W | Store data value |
| alloc_tag | input | TAG_W | Producer tag for missing store data |
| alloc_id | output | log2(DEPTH) | Identifier the next accepted entry gets |
| full | output | 1 | All slots occupied; allocation refused |
| bus_valid | input | 1 | Result bus broadcast present |
| bus_tag | input | TAG_W | Tag of the broadcast |
| bus_data | input | DATA_W | Value of the broadcast |
| mem_valid | output | 1 | Head entry is offered to memory |
| mem_ready | input | 1 | Memory port accepts this cycle |
| mem_is_store | output | 1 | Offered operation is a store |
| mem_addr | output | ADDR_W | Offered address |
| mem_wdata | output | DATA_W | Offered store data |
| mem_id | output | log2(DEPTH) | Identifier of the offered entry |

## Verification
The properties assume that the memory side holds no obligation of its own and that `mem_ready` may drop at any time. They also assume that allocation requests may arrive while the queue is full. The stimulus deliberately makes such refused requests and withholds `mem_ready` across several cycles. Tags broadcast on the result bus are assumed to belong to a single in-flight producer. The stimulus therefore never uses one tag for two waiting stores, so each broadcast value has exactly one expected destination.

// File: rtl/memq_pkg.sv
package memq_pkg;

    parameter int ADDR_W = 32;
    parameter int DATA_W = 32;
    parameter int TAG_W  = 5;

    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_STORE = 1'b1
    } memq_op_e;

    typedef struct packed {
        logic               valid;
        memq_op_e           op;
        logic               data_ok;
        logic [TAG_W-1:0]   tag;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  data;
    } memq_entry_t;

    // A broadcast satisfies a waiting operand when the tags agree.
    function automatic logic tag_hit(
        input logic             bv,
        input logic [TAG_W-1:0] btag,
        input logic [TAG_W-1:0] wtag
    );
        return bv && (btag == wtag);
    endfunction

    // Form a new descriptor, folding in a broadcast seen in the same cycle.
    function automatic memq_entry_t build_entry(
        input logic              is_store,
        input logic [ADDR_W-1:0] addr,
        input logic              data_ok,
        input logic [DATA_W-1:0] data,
        input logic [TAG_W-1:0]  tag,
        input logic              bv,
        input logic [TAG_W-1:0]  btag,
        input logic [DATA_W-1:0] bdata
    );
        memq_entry_t e;
        e.valid   = 1'b1;
        e.op      = is_store ? OP_STORE : OP_LOAD;
        e.addr    = addr;
        e.tag     = tag;
        e.data    = data;
        e.data_ok = 1'b1;
        if (is_store && !data_ok) begin
            if (tag_hit(bv, btag, tag)) begin
                e.data = bdata;
            end else begin
                e.data_ok = 1'b0;
            end
        end
        return e;
    endfunction

    // Head may go to memory: loads always, stores once data is present.
    function automatic logic can_issue(input memq_entry_t e);
        return e.valid && ((e.op == OP_LOAD) || e.data_ok);
    endfunction

endpackage

// File: rtl/memq_ctrl.sv
module memq_ctrl #(
    parameter int DEPTH = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        push,
    input  logic                        pop,
    output logic [$clog2(DEPTH)-1:0]    head_idx,
    output logic [$clog2(DEPTH)-1:0]    tail_idx,
    output logic [$clog2(DEPTH+1)-1:0]  occ,
    output logic                        full
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] MAX_OCC  = CNT_W'(DEPTH);

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i);
        return (i == LAST_IDX) ? '0 : i + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            head_idx <= '0;
            tail_idx <= '0;
            occ      <= '0;
        end else begin
            if (push) tail_idx <= step(tail_idx);
            if (pop)  head_idx <= step(head_idx);
            case ({push, pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    assign full = (occ == MAX_OCC);

endmodule

// File: rtl/memq_slot.sv
module memq_slot
    import memq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  memq_entry_t        wr_entry,
    input  logic               clr,
    input  logic               bus_valid,
    input  logic [TAG_W-1:0]   bus_tag,
    input  logic [DATA_W-1:0]  bus_data,
    output memq_entry_t        q
);
    logic snoop_hit;

    assign snoop_hit = q.valid && (q.op == OP_STORE) && !q.data_ok
                       && tag_hit(bus_valid, bus_tag, q.tag);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr_en) begin
            q <= wr_entry;
        end else if (clr) begin
            q.valid <= 1'b0;
        end else if (snoop_hit) begin
            q.data    <= bus_data;
            q.data_ok <= 1'b1;
        end
    end

endmodule

// File: rtl/memq_headsel.sv
module memq_headsel
    import memq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  memq_entry_t                 slots [DEPTH],
    input  logic [$clog2(DEPTH)-1:0]    head_idx,
    output memq_entry_t                 head
);
    always_comb begin
        head = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (head_idx == $clog2(DEPTH)'(i)) head = slots[i];
        end
    end

endmodule

// File: rtl/memop_queue.sv
module memop_queue
    import memq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        alloc_valid,
    input  logic                        alloc_is_store,
    input  logic [ADDR_W-1:0]           alloc_addr,
    input  logic                        alloc_data_ok,
    input  logic [DATA_W-1:0]           alloc_data,
    input  logic [TAG_W-1:0]            alloc_tag,
    output logic [$clog2(DEPTH)-1:0]    alloc_id,
    output logic                        full,
    input  logic                        bus_valid,
    input  logic [TAG_W-1:0]            bus_tag,
    input  logic [DATA_W-1:0]           bus_data,
    output logic                        mem_valid,
    input  logic                        mem_ready,
    output logic                        mem_is_store,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [DATA_W-1:0]           mem_wdata,
    output logic [$clog2(DEPTH)-1:0]    mem_id
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic               push;
    logic               pop;
    logic [IDX_W-1:0]   head_idx;
    logic [IDX_W-1:0]   tail_idx;
    logic [CNT_W-1:0]   occ;
    memq_entry_t        new_entry;
    memq_entry_t        slots [DEPTH];
    memq_entry_t        head;

    assign push = alloc_valid && !full;
    assign pop  = mem_valid && mem_ready;

    memq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .pop      (pop),
        .head_idx (head_idx),
        .tail_idx (tail_idx),
        .occ      (occ),
        .full     (full)
    );

    assign new_entry = build_entry(alloc_is_store, alloc_addr, alloc_data_ok,
                                   alloc_data, alloc_tag,
                                   bus_valid, bus_tag, bus_data);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        memq_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (push && (tail_idx == IDX_W'(g))),
            .wr_entry  (new_entry),
            .clr       (pop && (head_idx == IDX_W'(g))),
            .bus_valid (bus_valid),
            .bus_tag   (bus_tag),
            .bus_data  (bus_data),
            .q         (slots[g])
        );
    end

    memq_headsel #(.DEPTH(DEPTH)) u_sel (
        .slots    (slots),
        .head_idx (head_idx),
        .head     (head)
    );

    assign alloc_id     = tail_idx;
    assign mem_valid    = can_issue(head);
    assign mem_is_store = (head.op == OP_STORE);
    assign mem_addr     = head.addr;
    assign mem_wdata    = head.data;
    assign mem_id       = head_idx;

endmodule

// File: rtl/memop_queue_chk.sv
module memop_queue_chk
    import memq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        alloc_valid,
    input  logic                        full,
    input  logic                        mem_valid,
    input  logic                        mem_ready,
    input  logic                        mem_is_store,
    input  logic [ADDR_W-1:0]           mem_addr,
    input  logic [DATA_W-1:0]           mem_wdata,
    input  logic [$clog2(DEPTH)-1:0]    mem_id,
    input  logic [$clog2(DEPTH+1)-1:0]  occ
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    a_r1_idle_when_empty: assert property (@(posedge clk) disable iff (rst)
        (occ == '0) |-> !mem_valid);

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        occ <= CNT_W'(DEPTH));

    a_r3_refused_stays_full: assert property (@(posedge clk) disable iff (rst)
        (full && alloc_valid && !(mem_valid && mem_ready)) |=> full);

    a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
            && $stable(mem_wdata) && $stable(mem_id) && $stable(mem_is_store)));

    a_r2_pop_shrinks: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready && !(alloc_valid && !full))
            |=> (occ == $past(occ) - 1'b1));

endmodule

bind memop_queue memop_queue_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .alloc_valid  (alloc_valid),
    .full         (full),
    .mem_valid    (mem_valid),
    .mem_ready    (mem_ready),
    .mem_is_store (mem_is_store),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_id       (mem_id),
    .occ          (occ)
);

// File: tb/memop_queue_tb.sv
module memop_queue_tb;
    import memq_pkg::*;

    localparam int CLK_P = 10;
    localparam int DEPTH = 4;
    localparam int IDX_W = $clog2(DEPTH);

    typedef struct {
        logic              is_store;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [IDX_W-1:0]  id;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               alloc_valid = 1'b0;
    logic               alloc_is_store = 1'b0;
    logic [ADDR_W-1:0]  alloc_addr = '0;
    logic               alloc_data_ok = 1'b0;
    logic [DATA_W-1:0]  alloc_data = '0;
    logic [TAG_W-1:0]   alloc_tag = '0;
    logic [IDX_W-1:0]   alloc_id;
    logic               full;
    logic               bus_valid = 1'b0;
    logic [TAG_W-1:0]   bus_tag = '0;
    logic [DATA_W-1:0]  bus_data = '0;
    logic               mem_valid;
    logic               mem_ready = 1'b0;
    logic               mem_is_store;
    logic [ADDR_W-1:0]  mem_addr;
    logic [DATA_W-1:0]  mem_wdata;
    logic [IDX_W-1:0]   mem_id;

    int nchk  = 0;
    int nfail = 0;
    exp_t sb[$];
    logic [IDX_W-1:0] nid = '0;

    always #(CLK_P/2) clk = ~clk;

    memop_queue #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_is_store(alloc_is_store),
        .alloc_addr(alloc_addr), .alloc_data_ok(alloc_data_ok),
        .alloc_data(alloc_data), .alloc_tag(alloc_tag),
        .alloc_id(alloc_id), .full(full),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_is_store(mem_is_store), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_id(mem_id)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    // Driver: one allocation request in the coming cycle; exp_data is the
    // value the store must finally carry (R5, R7, R8).
    task automatic alloc1(input logic st, input logic [ADDR_W-1:0] a,
                          input logic ok, input logic [DATA_W-1:0] d,
                          input logic [TAG_W-1:0] t,
                          input logic [DATA_W-1:0] exp_data);
        exp_t e;
        @(negedge clk);
        alloc_valid    = 1'b1;
        alloc_is_store = st;
        alloc_addr     = a;
        alloc_data_ok  = ok;
        alloc_data     = d;
        alloc_tag      = t;
        #1;
        if (!full) begin
            check(alloc_id == nid, "R10 alloc_id", 64'(alloc_id), 64'(nid));
            e.is_store = st;
            e.addr     = a;
            e.data     = exp_data;
            e.id       = nid;
            sb.push_back(e);
            nid = (nid == IDX_W'(DEPTH - 1)) ? '0 : nid + 1'b1;
        end
    endtask

    task automatic quiet();
        @(negedge clk);
        alloc_valid = 1'b0;
        bus_valid   = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        int guard = 0;
        while (sb.size() != 0 && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        idle(2);
        check(sb.size() == 0, "R2 drain", 64'(sb.size()), 64'd0);
    endtask

    // Monitor: samples between the input change and the next rising edge.
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (!rst && mem_valid && mem_ready) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R3 unexpected dispatch", 64'(mem_addr), 64'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(mem_addr == e.addr, "R2 order addr", 64'(mem_addr), 64'(e.addr));
                    check(mem_is_store == e.is_store, "R4 op type",
                          64'(mem_is_store), 64'(e.is_store));
                    check(mem_id == e.id, "R10 mem_id", 64'(mem_id), 64'(e.id));
                    if (e.is_store)
                        check(mem_wdata == e.data, "R5 store data",
                              64'(mem_wdata), 64'(e.data));
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        check(1'b0, "watchdog", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        logic [ADDR_W-1:0] ha;
        logic [IDX_W-1:0]  hid;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(full == 1'b0, "R1 full", 64'(full), 64'd0);
        check(mem_valid == 1'b0, "R1 mem_valid", 64'(mem_valid), 64'd0);
        check(alloc_id == '0, "R1 alloc_id", 64'(alloc_id), 64'd0);

        // R4 R2 R10: loads stream through
        mem_ready = 1'b1;
        alloc1(1'b0, 32'h100, 1'b0, '0, '0, '0);
        alloc1(1'b0, 32'h104, 1'b0, '0, '0, '0);
        alloc1(1'b0, 32'h108, 1'b0, '0, '0, '0);
        quiet();
        drain();

        // R5: store with data at allocation
        alloc1(1'b1, 32'h200, 1'b1, 32'hCAFE0001, '0, 32'hCAFE0001);
        alloc1(1'b0, 32'h204, 1'b0, '0, '0, '0);
        quiet();
        drain();

        // R6 R7: waiting store blocks a younger load
        alloc1(1'b1, 32'h300, 1'b0, 32'hDEAD, 5'd5, 32'h0000AAAA);
        alloc1(1'b0, 32'h304, 1'b0, '0, '0, '0);
        quiet();
        idle(3);
        #3;
        check(mem_valid == 1'b0, "R6 store waits", 64'(mem_valid), 64'd0);
        check(sb.size() == 2, "R6 no bypass", 64'(sb.size()), 64'd2);
        @(negedge clk);
        bus_valid = 1'b1; bus_tag = 5'd7; bus_data = 32'h0000BBBB;
        @(negedge clk);
        bus_valid = 1'b0;
        #3;
        check(mem_valid == 1'b0, "R7 other tag ignored", 64'(mem_valid), 64'd0);
        @(negedge clk);
        bus_valid = 1'b1; bus_tag = 5'd5; bus_data = 32'h0000AAAA;
        @(negedge clk);
        bus_valid = 1'b0;
        #3;
        check(mem_valid == 1'b1, "R7 captured", 64'(mem_valid), 64'd1);
        drain();

        // R8: broadcast in the allocation cycle
        @(negedge clk);
        bus_valid = 1'b1; bus_tag = 5'd9; bus_data = 32'h12345678;
        #0;
        alloc_valid = 1'b0;
        nid = nid;
        begin
            exp_t e;
            alloc_valid = 1'b1; alloc_is_store = 1'b1; alloc_addr = 32'h400;
            alloc_data_ok = 1'b0; alloc_data = 32'h0; alloc_tag = 5'd9;
            #1;
            check(alloc_id == nid, "R10 alloc_id", 64'(alloc_id), 64'(nid));
            e.is_store = 1'b1; e.addr = 32'h400; e.data = 32'h12345678; e.id = nid;
            sb.push_back(e);
            nid = (nid == IDX_W'(DEPTH - 1)) ? '0 : nid + 1'b1;
        end
        quiet();
        #3;
        check(mem_valid == 1'b1, "R8 same-cycle capture", 64'(mem_valid), 64'd1);
        drain();

        // R3 R9: fill while memory is busy, then try one more
        mem_ready = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            alloc1(i[0], 32'h500 + 32'(i * 4), 1'b1, 32'hF000 + 32'(i), '0,
                   32'hF000 + 32'(i));
        quiet();
        #1;
        check(full == 1'b1, "R3 full", 64'(full), 64'd1);
        alloc1(1'b0, 32'h5FC, 1'b0, '0, '0, '0);
        quiet();
        check(sb.size() == DEPTH, "R3 refused", 64'(sb.size()), 64'(DEPTH));
        #3;
        ha  = mem_addr;
        hid = mem_id;
        idle(3);
        #3;
        check(mem_valid == 1'b1, "R9 still offered", 64'(mem_valid), 64'd1);
        check(mem_addr == ha, "R9 addr held", 64'(mem_addr), 64'(ha));
        check(mem_id == hid, "R9 id held", 64'(mem_id), 64'(hid));
        mem_ready = 1'b1;
        drain();
        check(full == 1'b0, "R3 full clears", 64'(full), 64'd0);

        finish_run();
    end

endmodule